// File: doc/BRIEF.md
# Format-Aware Floating-Point Register Bank

This block holds the floating-point register state of a processor core: four 64-bit registers that software addresses with the even numbers 0, 2, 4 and 6. It has two combinational read ports and one write port. Every access carries a format tag that selects one of three views. A short view covers the leftmost 32 bits of a register. A long view covers the whole register. An extended view spans a fixed pair of registers and carries a 128-bit operand.

Each port checks its register specifier against its format tag. An illegal combination is suppressed and the port raises its own specification-exception flag. A suppressed write leaves every register untouched. A suppressed read returns zeros. Short writes merge into the register, so the right half keeps its old contents. Extended accesses move the high-order part through the lower-numbered register of the pair and the low-order part through the higher-numbered one.

Top module: `fprf_bank`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears all four registers to zero. A long read of any register after reset returns 0.
- R2: A long access (format code 1) with specifier 0, 2, 4 or 6 writes or reads all 64 bits of register `spec/2` through the `_hi` bus. The read `_lo` bus is zero.
- R3: A short read (format code 0) returns the register's leftmost 32 bits (bits 63:32 of the bus) on `_hi[63:32]`. It returns zero on `_hi[31:0]` and on `_lo`.
- R4: A short write changes only bits 63:32 of the addressed register, taking them from `wr_hi[63:32]`. Bits 31:0 keep their previous value.
- R5: For short or long format, any specifier other than 0, 2, 4 or 6 (odd, or 8 and above) raises that port's exception flag. A write with such a specifier changes no register.
- R6: For extended format (code 2), only specifiers 0 and 4 are legal. Any other specifier raises the exception flag, and a write with it changes no register.
- R7: An extended write to specifier 0 or 4 stores `wr_hi` in register 0 or 4 and `wr_lo` in register 2 or 6 respectively. An extended read returns the pair the same way on `_hi` and `_lo`.
- R8: A read that raises its exception flag drives both of its data buses to zero.
- R9: A port whose enable is low raises no exception. It reads zeros on both buses and writes nothing, whatever its specifier and format.
- R10: Format code 3 is illegal for every specifier. It raises the exception flag and suppresses the access.
- R11: Writes take effect at the rising clock edge. A read of the target register in the same cycle as the write still returns the old value.
- R12: The two read ports work independently. Each decodes its own specifier and format in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rda_en | input | 1 | Read port A enable |
| rda_spec | input | 4 | Read port A register specifier |
| rda_fmt | input | 2 | Read port A format: 0 short, 1 long, 2 extended, 3 illegal |
| rda_hi | output | 64 | Read port A data, or high-order part for extended |
| rda_lo | output | 64 | Read port A low-order part (extended only) |
| rda_exc | output | 1 | Read port A specification exception |
| rdb_en | input | 1 | Read port B enable |
| rdb_spec | input | 4 | Read port B register specifier |
| rdb_fmt | input | 2 | Read port B format |
| rdb_hi | output | 64 | Read port B data, or high-order part |
| rdb_lo | output | 64 | Read port B low-order part |
| rdb_exc | output | 1 | Read port B specification exception |
| wr_en | input | 1 | Write port enable |
| wr_spec | input | 4 | Write port register specifier |
| wr_fmt | input | 2 | Write port format |
| wr_hi | input | 64 | Write data, or high-order part for extended |
| wr_lo | input | 64 | Low-order part for extended writes |
| wr_exc | output | 1 | Write port specification exception |

## Verification
The hardest case to reach from the ports is a suppressed write. Nothing comes out of the write port except the flag, so the proof that nothing changed has to come from rereading every register. The stimulus first loads distinct long patterns into all four registers. It then issues each illegal write: an odd specifier, a specifier of 8 or above, an extended access to register 2 or 6, and format code 3. After each one it reads back all four registers through the long view. The short-merge case is staged the same way. A known long pattern is loaded first, so a clobbered right half shows up as a mismatch.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    typedef enum logic [1:0] {
        FMT_SHORT = 2'd0,
        FMT_LONG  = 2'd1,
        FMT_EXT   = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

endpackage

// File: rtl/fprf_spec_check.sv
module fprf_spec_check
    import fprf_pkg::*;
#(
    parameter int SPEC_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic [SPEC_W-1:0] spec,
    input  fmt_e              fmt,
    output logic              legal,
    output logic [IDX_W-1:0]  idx
);

    logic in_range;

    // Even specifiers below 2*NUM_REGS map to register spec/2.
    always_comb begin
        idx      = spec[IDX_W:1];
        in_range = ~(|spec[SPEC_W-1:IDX_W+1]) & ~spec[0];
        unique case (fmt)
            FMT_SHORT, FMT_LONG: legal = in_range;
            FMT_EXT:             legal = in_range & ~spec[1];
            default:             legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
    import fprf_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 4,
    parameter int SPEC_W   = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank,
    input  logic                            en,
    input  logic [SPEC_W-1:0]               spec,
    input  fmt_e                            fmt,
    output logic [DATA_W-1:0]               hi,
    output logic [DATA_W-1:0]               lo,
    output logic                            exc
);

    localparam int HALF = DATA_W / 2;

    logic             legal;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pair_idx;

    fprf_spec_check #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_chk (
        .spec  (spec),
        .fmt   (fmt),
        .legal (legal),
        .idx   (idx)
    );

    always_comb begin
        pair_idx = {idx[IDX_W-1:1], 1'b1};
        hi       = '0;
        lo       = '0;
        exc      = en & ~legal;
        if (en && legal) begin
            unique case (fmt)
                FMT_SHORT: hi = {bank[idx][DATA_W-1 -: HALF], {HALF{1'b0}}};
                FMT_LONG:  hi = bank[idx];
                FMT_EXT: begin
                    hi = bank[idx];
                    lo = bank[pair_idx];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fprf_write_merge.sv
module fprf_write_merge
    import fprf_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 4,
    parameter int SPEC_W   = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q,
    input  logic                            en,
    input  logic [SPEC_W-1:0]               spec,
    input  fmt_e                            fmt,
    input  logic [DATA_W-1:0]               wdata_hi,
    input  logic [DATA_W-1:0]               wdata_lo,
    output logic [NUM_REGS-1:0][DATA_W-1:0] bank_d,
    output logic                            exc
);

    localparam int HALF = DATA_W / 2;

    logic             legal;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pair_idx;

    fprf_spec_check #(.SPEC_W(SPEC_W), .IDX_W(IDX_W)) u_chk (
        .spec  (spec),
        .fmt   (fmt),
        .legal (legal),
        .idx   (idx)
    );

    always_comb begin
        pair_idx = {idx[IDX_W-1:1], 1'b1};
        bank_d   = bank_q;
        exc      = en & ~legal;
        if (en && legal) begin
            unique case (fmt)
                FMT_SHORT: bank_d[idx][DATA_W-1 -: HALF] = wdata_hi[DATA_W-1 -: HALF];
                FMT_LONG:  bank_d[idx] = wdata_hi;
                FMT_EXT: begin
                    bank_d[idx]      = wdata_hi;
                    bank_d[pair_idx] = wdata_lo;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fprf_bank.sv
module fprf_bank
    import fprf_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 4,
    parameter int SPEC_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rda_en,
    input  logic [SPEC_W-1:0] rda_spec,
    input  logic [1:0]        rda_fmt,
    output logic [DATA_W-1:0] rda_hi,
    output logic [DATA_W-1:0] rda_lo,
    output logic              rda_exc,
    input  logic              rdb_en,
    input  logic [SPEC_W-1:0] rdb_spec,
    input  logic [1:0]        rdb_fmt,
    output logic [DATA_W-1:0] rdb_hi,
    output logic [DATA_W-1:0] rdb_lo,
    output logic              rdb_exc,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [1:0]        wr_fmt,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic [DATA_W-1:0] wr_lo,
    output logic              wr_exc
);

    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] merged;
    logic [NUM_REGS*DATA_W-1:0]      bank_flat;

    fprf_write_merge #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SPEC_W(SPEC_W), .IDX_W(IDX_W)
    ) u_wr (
        .bank_q   (st_q.regs),
        .en       (wr_en),
        .spec     (wr_spec),
        .fmt      (fmt_e'(wr_fmt)),
        .wdata_hi (wr_hi),
        .wdata_lo (wr_lo),
        .bank_d   (merged),
        .exc      (wr_exc)
    );

    fprf_read_port #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SPEC_W(SPEC_W), .IDX_W(IDX_W)
    ) u_rda (
        .bank (st_q.regs),
        .en   (rda_en),
        .spec (rda_spec),
        .fmt  (fmt_e'(rda_fmt)),
        .hi   (rda_hi),
        .lo   (rda_lo),
        .exc  (rda_exc)
    );

    fprf_read_port #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SPEC_W(SPEC_W), .IDX_W(IDX_W)
    ) u_rdb (
        .bank (st_q.regs),
        .en   (rdb_en),
        .spec (rdb_spec),
        .fmt  (fmt_e'(rdb_fmt)),
        .hi   (rdb_hi),
        .lo   (rdb_lo),
        .exc  (rdb_exc)
    );

    always_comb begin
        st_d.regs = merged;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bank_flat = st_q;

endmodule

// File: rtl/fprf_bank_chk.sv
module fprf_bank_chk #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 4,
    parameter int SPEC_W   = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_REGS*DATA_W-1:0] bank_flat,
    input logic                       rda_en,
    input logic [1:0]                 rda_fmt,
    input logic [DATA_W-1:0]          rda_hi,
    input logic [DATA_W-1:0]          rda_lo,
    input logic                       rda_exc,
    input logic                       wr_en,
    input logic [SPEC_W-1:0]          wr_spec,
    input logic [1:0]                 wr_fmt,
    input logic                       wr_exc
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int HALF  = DATA_W / 2;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] wr_idx_q;
    logic [HALF-1:0]  low_half_q;
    logic [HALF-1:0]  low_half_now;
    logic             short_wr;

    assign wr_idx       = wr_spec[IDX_W:1];
    assign short_wr     = wr_en && !wr_exc && (wr_fmt == 2'd0);
    assign low_half_now = bank_flat[int'(wr_idx_q)*DATA_W +: HALF];

    always_ff @(posedge clk) begin
        wr_idx_q   <= wr_idx;
        low_half_q <= bank_flat[int'(wr_idx)*DATA_W +: HALF];
    end

    a_r1_reset_clears: assert property (@(posedge clk) rst |=> bank_flat == '0);

    a_r4_short_keeps_right: assert property (@(posedge clk) disable iff (rst)
        $past(short_wr) |-> low_half_now == low_half_q);

    a_r5_suppressed_write: assert property (@(posedge clk) disable iff (rst)
        wr_exc |=> $stable(bank_flat));

    a_r6_ext_odd_pair: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fmt == 2'd2 && wr_spec[1]) |-> wr_exc);

    a_r8_exc_zero_data: assert property (@(posedge clk) disable iff (rst)
        rda_exc |-> (rda_hi == '0 && rda_lo == '0));

    a_r3_short_read_shape: assert property (@(posedge clk) disable iff (rst)
        (rda_en && rda_fmt == 2'd0) |-> (rda_hi[HALF-1:0] == '0 && rda_lo == '0));

    a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bank_flat));

    a_r10_rsvd_fmt: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fmt == 2'd3) |-> wr_exc);

endmodule

bind fprf_bank fprf_bank_chk #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SPEC_W(SPEC_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bank_flat (bank_flat),
    .rda_en    (rda_en),
    .rda_fmt   (rda_fmt),
    .rda_hi    (rda_hi),
    .rda_lo    (rda_lo),
    .rda_exc   (rda_exc),
    .wr_en     (wr_en),
    .wr_spec   (wr_spec),
    .wr_fmt    (wr_fmt),
    .wr_exc    (wr_exc)
);

// File: tb/fprf_bank_bench.sv
module fprf_bank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        rda_en, rdb_en, wr_en;
    logic [3:0]  rda_spec, rdb_spec, wr_spec;
    logic [1:0]  rda_fmt, rdb_fmt, wr_fmt;
    logic [63:0] rda_hi, rda_lo, rdb_hi, rdb_lo, wr_hi, wr_lo;
    logic        rda_exc, rdb_exc, wr_exc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [63:0] model [4];

    always #4 clk = ~clk;

    fprf_bank u_fprf_bank (
        .clk(clk), .rst(rst),
        .rda_en(rda_en), .rda_spec(rda_spec), .rda_fmt(rda_fmt),
        .rda_hi(rda_hi), .rda_lo(rda_lo), .rda_exc(rda_exc),
        .rdb_en(rdb_en), .rdb_spec(rdb_spec), .rdb_fmt(rdb_fmt),
        .rdb_hi(rdb_hi), .rdb_lo(rdb_lo), .rdb_exc(rdb_exc),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_fmt(wr_fmt),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_exc(wr_exc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [3:0] spec, input logic [1:0] fmt,
                            input logic [63:0] hi, input logic [63:0] lo,
                            output logic exc);
        @(negedge clk);
        wr_en = en; wr_spec = spec; wr_fmt = fmt; wr_hi = hi; wr_lo = lo;
        #1 exc = wr_exc;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_a(input logic [3:0] spec, input logic [1:0] fmt,
                          output logic [63:0] hi, output logic [63:0] lo, output logic exc);
        rda_en = 1'b1; rda_spec = spec; rda_fmt = fmt;
        #1 hi = rda_hi; lo = rda_lo; exc = rda_exc;
        rda_en = 1'b0;
    endtask

    // Long read of every register through port A against the bench model.
    task automatic check_all(input string req);
        logic [63:0] h, l;
        logic e;
        for (int r = 0; r < 4; r++) begin
            read_a(4'(2 * r), 2'd1, h, l, e);
            chk(req, h, model[r]);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset clears");
        chk("R9 idle port A exc", {63'd0, rda_exc}, 64'd0);
        chk("R9 idle port A data", rda_hi, 64'd0);
    endtask

    task automatic t_long;
        logic e;
        logic [63:0] h, l;
        for (int r = 0; r < 4; r++) begin
            model[r] = 64'h1111_0000_0000_0001 * 64'(r + 1) ^ 64'hA5A5_5A5A_0F0F_F0F0;
            do_write(1'b1, 4'(2 * r), 2'd1, model[r], 64'hDEAD, e);
            chk("R2 long write no exc", {63'd0, e}, 64'd0);
        end
        check_all("R2 long readback");
        read_a(4'd2, 2'd1, h, l, e);
        chk("R2 long read lo zero", l, 64'd0);
        // R12: both read ports decode independently in the same cycle
        rda_en = 1'b1; rda_spec = 4'd0; rda_fmt = 2'd1;
        rdb_en = 1'b1; rdb_spec = 4'd6; rdb_fmt = 2'd0;
        #1;
        chk("R12 port A long", rda_hi, model[0]);
        chk("R12 port B short", rdb_hi, {model[3][63:32], 32'd0});
        rdb_spec = 4'd7; rdb_fmt = 2'd1;
        #1;
        chk("R12 port B exc alone", {62'd0, rdb_exc, rda_exc}, 64'd2);
        rda_en = 1'b0; rdb_en = 1'b0;
    endtask

    task automatic t_short;
        logic e;
        logic [63:0] h, l;
        do_write(1'b1, 4'd6, 2'd0, 64'hCAFE_BABE_1234_5678, 64'd0, e);
        model[3][63:32] = 32'hCAFE_BABE;
        chk("R4 short write no exc", {63'd0, e}, 64'd0);
        check_all("R4 short write keeps right half");
        read_a(4'd6, 2'd0, h, l, e);
        chk("R3 short read hi", h, 64'hCAFE_BABE_0000_0000);
        chk("R3 short read lo", l, 64'd0);
    endtask

    task automatic t_bad_spec;
        logic e;
        logic [63:0] h, l;
        do_write(1'b1, 4'd3, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, e);
        chk("R5 odd spec exc", {63'd0, e}, 64'd1);
        check_all("R5 odd spec suppressed");
        do_write(1'b1, 4'd8, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, e);
        chk("R5 spec 8 exc", {63'd0, e}, 64'd1);
        check_all("R5 spec 8 suppressed");
        read_a(4'd5, 2'd0, h, l, e);
        chk("R5 read odd exc", {63'd0, e}, 64'd1);
        chk("R8 suppressed read hi", h, 64'd0);
        chk("R8 suppressed read lo", l, 64'd0);
    endtask

    task automatic t_ext;
        logic e;
        logic [63:0] h, l;
        do_write(1'b1, 4'd4, 2'd2, 64'h4444_0000_AAAA_0001, 64'h6666_0000_BBBB_0002, e);
        model[2] = 64'h4444_0000_AAAA_0001;
        model[3] = 64'h6666_0000_BBBB_0002;
        chk("R7 ext write no exc", {63'd0, e}, 64'd0);
        check_all("R7 ext pair placement");
        read_a(4'd4, 2'd2, h, l, e);
        chk("R7 ext read hi", h, model[2]);
        chk("R7 ext read lo", l, model[3]);
        read_a(4'd0, 2'd2, h, l, e);
        chk("R7 ext read pair 0 lo", l, model[1]);
    endtask

    task automatic t_ext_bad;
        logic e;
        logic [63:0] h, l;
        do_write(1'b1, 4'd2, 2'd2, 64'h0BAD, 64'h0BAD, e);
        chk("R6 ext spec 2 exc", {63'd0, e}, 64'd1);
        check_all("R6 ext spec 2 suppressed");
        read_a(4'd6, 2'd2, h, l, e);
        chk("R6 ext read spec 6 exc", {63'd0, e}, 64'd1);
        chk("R8 ext suppressed lo", l, 64'd0);
    endtask

    task automatic t_rsvd_fmt;
        logic e;
        logic [63:0] h, l;
        do_write(1'b1, 4'd0, 2'd3, 64'h0BAD, 64'h0BAD, e);
        chk("R10 fmt 3 write exc", {63'd0, e}, 64'd1);
        check_all("R10 fmt 3 suppressed");
        read_a(4'd4, 2'd3, h, l, e);
        chk("R10 fmt 3 read exc", {63'd0, e}, 64'd1);
        chk("R10 fmt 3 read zero", h, 64'd0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 4'd2; wr_fmt = 2'd1; wr_hi = 64'h7777_8888_9999_AAAA;
        rda_en = 1'b1; rda_spec = 4'd2; rda_fmt = 2'd1;
        #1 chk("R11 same cycle old value", rda_hi, model[1]);
        @(posedge clk);
        #1 chk("R11 after edge new value", rda_hi, 64'h7777_8888_9999_AAAA);
        model[1] = 64'h7777_8888_9999_AAAA;
        @(negedge clk);
        wr_en = 1'b0; rda_en = 1'b0;
    endtask

    task automatic t_disabled;
        logic e;
        do_write(1'b0, 4'd3, 2'd3, 64'hFFFF, 64'hFFFF, e);
        chk("R9 disabled write no exc", {63'd0, e}, 64'd0);
        check_all("R9 disabled write no change");
        rda_en = 1'b0; rda_spec = 4'd0; rda_fmt = 2'd1;
        #1 chk("R9 disabled read zero", rda_hi, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) model[r] = 64'd0;
        rst = 1'b1;
        rda_en = 0; rdb_en = 0; wr_en = 0;
        rda_spec = 0; rdb_spec = 0; wr_spec = 0;
        rda_fmt = 0; rdb_fmt = 0; wr_fmt = 0;
        wr_hi = 0; wr_lo = 0;
        t_reset();
        t_long();
        t_short();
        t_bad_spec();
        t_ext();
        t_ext_bad();
        t_rsvd_fmt();
        t_timing();
        t_disabled();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule